// File: doc/BRIEF.md
# Bit Clock and Frame Sync Generator

This block produces the bit clock and the frame sync of a serial audio port when the port is the timing master. It divides the system clock by a programmable ratio to form bit periods. It then counts bit periods to form frames of a programmable length, and asserts the frame sync for a programmable number of bit periods at the start of each frame. A one-cycle bit strobe marks the last system-clock cycle of every bit period, so that the shifters which follow can work on the system clock.

When the port is a timing slave, the block hands the external bit clock and frame sync straight through and releases its pad drive. Both outputs have a polarity control that applies in either mode. Two typical settings: an I2S-style frame loads the width field with half the frame length minus one, and a DSP-style frame loads it with zero, which gives a single-bit pulse. If the width field is not smaller than the period field, the block raises an error flag and holds the frame sync inactive.

Top module: `frame_sync_gen`

## Requirements
- R1: The divider field D sets a bit period of D+1 system clocks, so a field of 0 divides by one. The bit strobe is high in exactly one cycle of each bit period: the last one, at counter value D.
- R2: Within a bit period, the bit clock before inversion is high for the first floor((D+1)/2) cycles and low for the rest. An odd ratio therefore has a high phase one cycle shorter than its low phase. With D=0 the bit clock stays low.
- R3: The period field P sets a frame of P+1 bit periods. A frame begins at the first bit period after reset.
- R4: Before inversion, the frame sync is high for the first W+1 bit periods of each frame, where W is the width field.
- R5: When W >= P in master mode, the error flag is high and the frame sync stays at its inactive level (equal to its inversion input).
- R6: In slave mode (master input low), the bit clock and frame sync outputs follow the external inputs, XORed with their inversion inputs. The pad-drive output, the bit strobe and the error flag are all low.
- R7: Each inversion input set to 1 inverts its own output and leaves the other output unchanged.
- R8: While reset is held in master mode, both counters are at zero. The pad-drive output equals the master input at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_i | input | 1 | 1: generate timing; 0: pass external timing through |
| clk_div_i | input | DIV_W | Divide ratio minus one |
| frame_per_i | input | FRM_W | Frame length in bit periods minus one |
| fs_width_i | input | FRM_W | Frame-sync width in bit periods minus one |
| bclk_inv_i | input | 1 | Invert the bit clock output |
| fs_inv_i | input | 1 | Invert the frame sync output |
| ext_bclk_i | input | 1 | External bit clock (slave mode) |
| ext_fs_i | input | 1 | External frame sync (slave mode) |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| bit_tick_o | output | 1 | Strobe on the last cycle of a bit period |
| pins_drive_o | output | 1 | Pad output enable for bit clock and frame sync |
| cfg_err_o | output | 1 | Width field not below period field |

## Verification
A wrong divide count shows up at once as a misplaced bit strobe or bit-clock edge, within one bit period of the fault. A wrong frame count stays hidden until the frame-sync edge it moves, which can be up to P+1 bit periods away. For that reason every configuration runs for two full frames, and every cycle is compared with a value computed from the elapsed cycle count. Errors in the polarity or the mode multiplexing show up on the very next sample, so the slave sweep drives all combinations of external levels and inversion inputs.

// File: rtl/frame_sync_pkg.sv
// Package: shared types for the bit clock / frame sync generator.
// Assumes nothing beyond IEEE 1800-2017.
package frame_sync_pkg;
    // A timing line pair: bit clock and frame sync.
    typedef struct packed {
        logic bclk;
        logic fs;
    } sync_pair_t;
endpackage

// File: rtl/fsg_bit_divider.sv
// Module: divides the system clock into bit periods of clk_div_i+1 cycles.
// Assumes clk_div_i is normally held steady; a lowered value takes effect
// at once because the wrap compare uses >=.
module fsg_bit_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             bclk_o,
    output logic             tick_o
);
    localparam int NW = DIV_W + 1;

    logic [DIV_W-1:0] phase_q;
    logic [NW-1:0]    ratio;
    logic [NW-1:0]    high_len;
    logic             at_end;

    // Ratio and the length of the high phase (floor of half the ratio).
    always_comb begin
        ratio    = {1'b0, div_i} + NW'(1);
        high_len = ratio >> 1;
        at_end   = (phase_q >= div_i);
    end

    // Phase counter: wraps after the last cycle of a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= '0;
        end else if (at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

    assign bclk_o = ({1'b0, phase_q} < high_len);
    assign tick_o = run_i && at_end;
endmodule

// File: rtl/fsg_frame_counter.sv
// Module: counts bit periods into frames and forms the frame sync pulse.
// Assumes tick_i is high for one cycle per bit period.
module fsg_frame_counter #(
    parameter int FRM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [FRM_W-1:0] per_i,
    input  logic [FRM_W-1:0] width_i,
    output logic             fs_o,
    output logic             err_o
);
    logic [FRM_W-1:0] slot_q;
    logic             bad_cfg;

    // Configuration check: the pulse must be shorter than the frame.
    always_comb bad_cfg = (width_i >= per_i);

    // Bit-slot counter: advances once per bit period, wraps at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            slot_q <= '0;
        end else if (tick_i) begin
            if (slot_q >= per_i) slot_q <= '0;
            else                 slot_q <= slot_q + FRM_W'(1);
        end
    end

    assign fs_o  = run_i && !bad_cfg && (slot_q <= width_i);
    assign err_o = run_i && bad_cfg;
endmodule

// File: rtl/fsg_pin_select.sv
// Module: picks generated or external timing and applies polarity.
// Assumes the external inputs are already synchronous to clk.
module fsg_pin_select
    import frame_sync_pkg::*;
(
    input  logic       master_i,
    input  sync_pair_t gen_i,
    input  sync_pair_t ext_i,
    input  sync_pair_t inv_i,
    output sync_pair_t pin_o
);
    // Source select, then polarity.
    always_comb begin
        pin_o = master_i ? gen_i : ext_i;
        pin_o = pin_o ^ inv_i;
    end
endmodule

// File: rtl/frame_sync_gen.sv
// Module: top of the bit clock and frame sync generator.
// Assumes a synchronous active-low reset and configuration that is held
// steady while timing runs; a change restarts neither counter.
module frame_sync_gen
    import frame_sync_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int FRM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_i,
    input  logic [DIV_W-1:0] clk_div_i,
    input  logic [FRM_W-1:0] frame_per_i,
    input  logic [FRM_W-1:0] fs_width_i,
    input  logic             bclk_inv_i,
    input  logic             fs_inv_i,
    input  logic             ext_bclk_i,
    input  logic             ext_fs_i,
    output logic             bclk_o,
    output logic             fs_o,
    output logic             bit_tick_o,
    output logic             pins_drive_o,
    output logic             cfg_err_o
);
    sync_pair_t gen_pair, ext_pair, inv_pair, pin_pair;
    logic       tick;

    fsg_bit_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (master_i),
        .div_i  (clk_div_i),
        .bclk_o (gen_pair.bclk),
        .tick_o (tick)
    );

    fsg_frame_counter #(.FRM_W(FRM_W)) u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (master_i),
        .tick_i  (tick),
        .per_i   (frame_per_i),
        .width_i (fs_width_i),
        .fs_o    (gen_pair.fs),
        .err_o   (cfg_err_o)
    );

    // Gather the external and polarity inputs into line pairs.
    always_comb begin
        ext_pair.bclk = ext_bclk_i;
        ext_pair.fs   = ext_fs_i;
        inv_pair.bclk = bclk_inv_i;
        inv_pair.fs   = fs_inv_i;
    end

    fsg_pin_select u_pin (
        .master_i (master_i),
        .gen_i    (gen_pair),
        .ext_i    (ext_pair),
        .inv_i    (inv_pair),
        .pin_o    (pin_pair)
    );

    assign bclk_o       = pin_pair.bclk;
    assign fs_o         = pin_pair.fs;
    assign bit_tick_o   = tick;
    assign pins_drive_o = master_i;
endmodule

// File: rtl/frame_sync_gen_chk.sv
// Checker: port-level properties of frame_sync_gen, attached by bind.
module frame_sync_gen_chk #(
    parameter int DIV_W = 8,
    parameter int FRM_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_i,
    input logic [DIV_W-1:0] clk_div_i,
    input logic [FRM_W-1:0] frame_per_i,
    input logic [FRM_W-1:0] fs_width_i,
    input logic             bclk_inv_i,
    input logic             fs_inv_i,
    input logic             ext_bclk_i,
    input logic             ext_fs_i,
    input logic             bclk_o,
    input logic             fs_o,
    input logic             bit_tick_o,
    input logic             cfg_err_o
);
    // Slave mode passes the external lines through with polarity.
    p_slave_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |-> (bclk_o == (ext_bclk_i ^ bclk_inv_i)) &&
                      (fs_o == (ext_fs_i ^ fs_inv_i)) && !bit_tick_o && !cfg_err_o);

    // A bad width/period pair keeps the frame sync inactive.
    p_err_fs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (fs_o == fs_inv_i));

    // The strobe falls in the low phase whenever the ratio is at least two.
    p_tick_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick_o && clk_div_i != '0) |-> (bclk_o == bclk_inv_i));

    // A frame sync only starts right after a bit-period boundary.
    p_fs_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && $past(master_i) && $past(rst_n) && !cfg_err_o &&
         $stable(fs_inv_i) && $stable(fs_width_i) && $stable(frame_per_i) &&
         $rose(fs_o ^ fs_inv_i)) |-> $past(bit_tick_o));
endmodule

bind frame_sync_gen frame_sync_gen_chk #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_i    (master_i),
    .clk_div_i   (clk_div_i),
    .frame_per_i (frame_per_i),
    .fs_width_i  (fs_width_i),
    .bclk_inv_i  (bclk_inv_i),
    .fs_inv_i    (fs_inv_i),
    .ext_bclk_i  (ext_bclk_i),
    .ext_fs_i    (ext_fs_i),
    .bclk_o      (bclk_o),
    .fs_o        (fs_o),
    .bit_tick_o  (bit_tick_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_frame_sync_gen.sv
module sim_frame_sync_gen;
    localparam int DIV_W = 8;
    localparam int FRM_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_i = 1'b1;
    logic [DIV_W-1:0] clk_div_i = '0;
    logic [FRM_W-1:0] frame_per_i = '0;
    logic [FRM_W-1:0] fs_width_i = '0;
    logic bclk_inv_i = 1'b0, fs_inv_i = 1'b0, ext_bclk_i = 1'b0, ext_fs_i = 1'b0;
    logic bclk_o, fs_o, bit_tick_o, pins_drive_o, cfg_err_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    frame_sync_gen #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .clk_div_i(clk_div_i),
        .frame_per_i(frame_per_i), .fs_width_i(fs_width_i),
        .bclk_inv_i(bclk_inv_i), .fs_inv_i(fs_inv_i),
        .ext_bclk_i(ext_bclk_i), .ext_fs_i(ext_fs_i),
        .bclk_o(bclk_o), .fs_o(fs_o), .bit_tick_o(bit_tick_o),
        .pins_drive_o(pins_drive_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d (div=%0d per=%0d w=%0d)",
                     req, what, act, exp, clk_div_i, frame_per_i, fs_width_i);
        end
    endtask

    // Run one master configuration from reset and compare every cycle.
    task automatic run_master(input int d, input int p, input int w, input bit bi, input bit fi);
        int n, cycles;
        @(negedge clk);
        rst_n = 1'b0; master_i = 1'b1;
        clk_div_i = DIV_W'(d); frame_per_i = FRM_W'(p); fs_width_i = FRM_W'(w);
        bclk_inv_i = bi; fs_inv_i = fi;
        @(negedge clk);
        rst_n = 1'b1;
        n = d + 1;
        cycles = 2 * n * (p + 1) + 1;
        for (int t = 0; t < cycles; t++) begin
            int ph, slot;
            bit eb, ef, et, ee;
            ph   = t % n;
            slot = (t / n) % (p + 1);
            eb   = (ph < n / 2);
            et   = (ph == n - 1);
            ee   = (w >= p);
            ef   = !ee && (slot <= w);
            check("R1", "tick", int'(bit_tick_o), int'(et));
            check(bi ? "R7" : "R2", "bclk", int'(bclk_o), int'(eb ^ bi));
            if (ee) check("R5", "fs", int'(fs_o), int'(fi));
            else    check(fi ? "R7" : (slot == 0 ? "R3" : "R4"), "fs", int'(fs_o), int'(ef ^ fi));
            check("R5", "err", int'(cfg_err_o), int'(ee));
            check("R8", "drive", int'(pins_drive_o), 1);
            @(negedge clk);
        end
    endtask

    initial begin
        // Reset state with ratio 4: phase 0 is a high, non-end cycle.
        clk_div_i = DIV_W'(3); frame_per_i = FRM_W'(3); fs_width_i = FRM_W'(1);
        repeat (3) @(negedge clk);
        check("R8", "reset bclk", int'(bclk_o), 1);
        check("R8", "reset tick", int'(bit_tick_o), 0);
        check("R8", "reset fs", int'(fs_o), 1);
        check("R8", "reset drive", int'(pins_drive_o), 1);

        // Master sweep.
        for (int d = 0; d < 5; d++)
            for (int p = 0; p < 6; p++)
                for (int w = 0; w < 7; w++)
                    run_master(d, p, w, 1'b0, 1'b0);
        // Polarity combinations on a few shapes.
        for (int k = 1; k < 4; k++) begin
            run_master(2, 4, 1, k[0], k[1]);
            run_master(1, 3, 3, k[0], k[1]);
        end

        // Slave sweep: pass-through of every level and inversion combination.
        @(negedge clk);
        master_i = 1'b0; clk_div_i = DIV_W'(2); frame_per_i = FRM_W'(1); fs_width_i = FRM_W'(5);
        for (int v = 0; v < 32; v++) begin
            ext_bclk_i = v[0]; ext_fs_i = v[1]; bclk_inv_i = v[2]; fs_inv_i = v[3];
            @(negedge clk);
            check("R6", "bclk", int'(bclk_o), int'(v[0] ^ v[2]));
            check("R6", "fs", int'(fs_o), int'(v[1] ^ v[3]));
            check("R6", "tick", int'(bit_tick_o), 0);
            check("R6", "err", int'(cfg_err_o), 0);
            check("R8", "drive", int'(pins_drive_o), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule